// File: doc/BRIEF.md
# Pipelined Block Read Master

This block fetches a run of consecutive words from a memory-mapped slave and hands each returned word to a local output stream. A start pulse loads a byte base address and a word count. The block then issues one read request per clock. It does not wait for earlier data to come back. A separate read-data-valid strobe from the slave tells it when each word arrives.

The block counts the reads that the slave has accepted but not yet answered. It stops issuing when that count reaches a parameterised ceiling. This lets a pipelined slave deliver one word per clock once its pipeline has filled.

The same block also works, with no change, against a slave that is not pipelined. Such a slave holds the wait-request line high until it can serve the access. It may return the data in the same cycle the request is accepted. When the last expected word has arrived, the block pulses a done flag and goes idle.

Top module: `pipe_read_master`

## Requirements
- R1: After reset, `rd_req`, `busy`, `done` and `out_valid` are all low.
- R2: A start pulse with a non-zero count, sampled while idle, raises `busy` at that clock edge. The first request, addressed at `base_addr`, is presented in the very next cycle.
- R3: While `rd_req` is high and `rd_wait` is high, `rd_req` stays high and `rd_addr` stays unchanged in the following cycle.
- R4: The address advances by DW/8 bytes only on a cycle where a request is accepted (`rd_req` high, `rd_wait` low). Exactly `word_count` requests are accepted per job, at `base_addr + k*DW/8` for k = 0 to count-1.
- R5: The number of accepted reads whose data has not yet returned never exceeds MAX_PEND.
- R6: Suppose `rd_wait` stays low and the slave answers each read a fixed L cycles after acceptance, with L < MAX_PEND. Then one request is accepted on every clock. `done` appears count+L+1 cycles after the cycle in which start was driven, counting cycles of the clock.
- R7: Every cycle in which `rd_valid` is high while busy produces `out_valid` high, with `out_data` equal to `rd_data`. Words therefore leave in request order.
- R8: `done` is high for exactly one cycle: the cycle after the one that carried the last expected `rd_valid`. `busy` is low in that same cycle.
- R9: A start pulse while `busy` is high is ignored. The running job's addresses, word count and completion are unchanged.
- R10: A start pulse with a zero count issues no request. It raises `done` for one cycle, in the cycle right after start was sampled.
- R11: `rd_valid` pulses while idle produce no `out_valid` and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; sampled only while idle |
| base_addr | input | AW | Byte address of the first word |
| word_count | input | CW | Number of words to read |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at job completion |
| rd_req | output | 1 | Read request to the slave |
| rd_addr | output | AW | Byte address of the current request |
| rd_wait | input | 1 | Slave stall; the request is not accepted while high |
| rd_valid | input | 1 | Slave strobe marking a returned word |
| rd_data | input | DW | Returned word |
| out_valid | output | 1 | Output stream word present |
| out_data | output | DW | Output stream word |

## Verification
The bench builds the block with AW=16, DW=32, CW=4 and MAX_PEND=3. Counts of 0 to 7 then cover empty jobs, single words and jobs longer than the outstanding ceiling.

A modelled slave sweeps return latency from 0 to 4 and four stall patterns: none, alternate, two-of-three, and pseudo-random. Latency 0 stands in for the non-pipelined slave. Latencies 3 and 4 meet or pass the ceiling, so throttling shows up alongside the full-rate cases.

Overlapping start pulses and stray valid strobes between jobs are mixed into the same sweep.

// File: rtl/pipe_read_master.sv
module pipe_read_master #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CW       = 16,
  parameter int MAX_PEND = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] word_count,
  output logic          busy,
  output logic          done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_wait,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int BYTES = DW / 8;
  localparam int PW    = $clog2(MAX_PEND + 1);

  logic          run;
  logic          done_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] issue_left;
  logic [CW-1:0] recv_left;
  logic [PW-1:0] pend;

  logic accept, beat, last;

  assign rd_req    = run && (issue_left != '0) && (pend < PW'(MAX_PEND));
  assign rd_addr   = addr_q;
  assign accept    = rd_req && !rd_wait;
  assign beat      = run && rd_valid;
  assign last      = beat && (recv_left == CW'(1));
  assign busy      = run;
  assign done      = done_q;
  assign out_valid = beat;
  assign out_data  = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      done_q     <= 1'b0;
      addr_q     <= '0;
      issue_left <= '0;
      recv_left  <= '0;
      pend       <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start) begin
          addr_q     <= base_addr;
          issue_left <= word_count;
          recv_left  <= word_count;
          pend       <= '0;
          if (word_count == '0) done_q <= 1'b1;
          else                  run    <= 1'b1;
        end
      end else begin
        if (accept) begin
          addr_q     <= addr_q + AW'(BYTES);
          issue_left <= issue_left - CW'(1);
        end
        if (beat) recv_left <= recv_left - CW'(1);
        pend <= pend + PW'(accept) - PW'(beat);
        if (last) begin
          run    <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pipe_read_master_checks.sv
module pipe_read_master_checks #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int MAX_PEND = 4,
  parameter int PW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_wait,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] pend
);
  localparam int BYTES = DW / 8;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_wait) |=> (rd_req && rd_addr == $past(rd_addr)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_wait) |=> (!rd_req || rd_addr == $past(rd_addr) + AW'(BYTES)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PEND));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind pipe_read_master pipe_read_master_checks #(
  .AW(AW), .DW(DW), .MAX_PEND(MAX_PEND), .PW(PW)
) u_checks (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_wait(rd_wait),
  .rd_addr(rd_addr), .busy(busy), .done(done), .pend(pend)
);

// File: tb/tb_pipe_read_master.sv
module tb_pipe_read_master;
  localparam int AW = 16, DW = 32, CW = 4, MAXP = 3;
  localparam logic [DW-1:0] KEY = 32'h5A3C_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic busy, done, rd_req, rd_wait, rd_valid, out_valid;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data, out_data;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int lat = 1, mode = 0;
  logic stray = 1'b0;
  logic [7:0] pv;
  logic [DW-1:0] pd [8];
  logic [4:0] lfsr;
  logic acc;

  always #2 clk = ~clk;

  pipe_read_master #(.AW(AW), .DW(DW), .CW(CW), .MAX_PEND(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_count(word_count), .busy(busy), .done(done), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_wait(rd_wait), .rd_valid(rd_valid),
    .rd_data(rd_data), .out_valid(out_valid), .out_data(out_data));

  assign rd_wait  = (mode == 1) ? cyc[0] : (mode == 2) ? (cyc % 3 != 0) :
                    (mode == 3) ? lfsr[0] : 1'b0;
  assign acc      = rd_req && !rd_wait;
  assign rd_valid = stray || ((lat == 0) ? acc : pv[lat-1]);
  assign rd_data  = (lat == 0) ? ({16'h0, rd_addr} ^ KEY) : pd[lat-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0; lfsr <= 5'h1B;
      for (int i = 0; i < 8; i++) pd[i] <= '0;
    end else begin
      pv   <= {pv[6:0], acc};
      pd[0] <= {16'h0, rd_addr} ^ KEY;
      for (int i = 1; i < 8; i++) pd[i] <= pd[i-1];
      lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cyc %0d lat %0d mode %0d)",
               req, act, exp, cyc, lat, mode);
    end
  endtask

  task automatic run_job(input int base, input int cnt, input bit overlap);
    int k = 0, nacc = 0, nbeat = 0, outst = 0, last_k = -1;
    bit prev_stall = 0, seen_done = 0;
    logic [AW-1:0] prev_addr = '0;
    @(negedge clk);
    base_addr = AW'(base); word_count = CW'(cnt); start = 1'b1;
    while (!seen_done && k < 200) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        start = 1'b0;
        if (cnt > 0) chk(busy && rd_req && rd_addr == AW'(base), "R2", int'(rd_addr), base);
      end
      if (prev_stall) chk(rd_req && rd_addr == prev_addr, "R3", int'(rd_addr), int'(prev_addr));
      if (acc) begin
        chk(rd_addr == AW'(base + 4*nacc), "R4", int'(rd_addr), base + 4*nacc);
        nacc++;
      end
      if (out_valid) begin
        chk(out_data == ({16'h0, AW'(base + 4*nbeat)} ^ KEY), "R7",
            int'(out_data), int'({16'h0, AW'(base + 4*nbeat)} ^ KEY));
        nbeat++;
        if (nbeat == cnt) last_k = k;
      end
      outst = outst + int'(acc) - int'(out_valid);
      chk(outst <= MAXP, "R5", outst, MAXP);
      if (done) begin
        seen_done = 1;
        if (cnt == 0) chk(k == 1, "R10", k, 1);
        else chk(k == last_k + 1 && !busy, "R8", k, last_k + 1);
        if (mode == 0 && lat < MAXP && cnt > 0) chk(k == cnt + lat + 1, "R6", k, cnt + lat + 1);
      end
      prev_stall = rd_req && rd_wait;
      prev_addr  = rd_addr;
      if (overlap && k == 2) begin
        base_addr = AW'(base + 16'h400); word_count = CW'(1); start = 1'b1;
      end
      if (overlap && k == 3) start = 1'b0;
    end
    chk(seen_done, "R8", int'(seen_done), 1);
    chk(nacc == cnt, overlap ? "R9" : "R4", nacc, cnt);
    chk(nbeat == cnt, overlap ? "R9" : "R7", nbeat, cnt);
    if (cnt == 0) chk(nacc == 0, "R10", nacc, 0);
    @(negedge clk);
    chk(!done && !busy && !rd_req, "R8", int'(done), 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req && !busy && !done && !out_valid, "R1", int'(rd_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req && !busy && !done && !out_valid, "R1", int'(busy), 0);
    for (int l = 0; l <= 4; l++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c <= 7; c++) begin
          lat = l; mode = m;
          run_job(16'h0100 + 32*c + 4*m, c, (c >= 3) && (m != 1));
        end
    lat = 2; mode = 0;
    stray = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!out_valid && !done && !busy, "R11", int'(out_valid), 0);
    end
    stray = 1'b0;
    repeat (4) @(negedge clk);
    run_job(16'h0800, 5, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #600000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule